// File: doc/BRIEF.md
# Processor Run/Halt Command Controller

This block tracks which of a cluster's virtual processors are executing, and it turns software commands into per-processor control pulses. Software writes a bit vector to a start command register. Every listed processor that is currently idle receives a one-cycle restart request and is then marked as executing. A write to a halt command register does the opposite: every listed processor that is executing receives a one-cycle halt request and is then marked idle. A status register returns the vector of executing processors.

The three registers can be reached through two address windows, a local one and a remote one, and both behave identically. When reset is released, a start mask fixed at build time goes through the same start path, so the selected processors are restarted and marked as executing without any software action. Command bits at positions for processors that do not exist are dropped.

The register bus is plain control. A write is accepted in the cycle `bus_we` is high and cannot be stalled. Read data is combinational from `bus_addr`. No stream interface and no back-pressure exist.

Top module: `vp_runctl_top`

## Requirements
- R1: While `rst_n` is low, `vp_active` is all zero and no `vp_restart` or `vp_halt` pulse is driven.
- R2: On the first clock edge after reset is released, every processor selected by START_MASK gets a `vp_restart` pulse and its `vp_active` bit is set. START_MASK must have no bit at or above NUM_VP.
- R3: A write to the start register (offset 0x08 within a window) gives each listed processor that is idle a `vp_restart` pulse on the next clock edge, and sets its `vp_active` bit at that same edge.
- R4: A start bit for a processor that is already active produces no `vp_restart` pulse, and the processor's `vp_active` bit stays 1.
- R5: A write to the halt register (offset 0x10) gives each listed active processor a `vp_halt` pulse on the next clock edge, and clears its `vp_active` bit at that same edge.
- R6: A halt bit for an idle processor produces no `vp_halt` pulse, and its `vp_active` bit stays 0.
- R7: Write-data bits at positions NUM_VP and above are ignored by both commands.
- R8: The local window (base 0x000) and the remote window (base 0x100) decode the same three registers with identical effect.
- R9: A read of the status register (offset 0x18) returns `vp_active` zero-extended to the bus width. A read of any other address, including the two command registers, returns zero.
- R10: A write to any address other than the four command registers changes no state and produces no pulse.
- R11: Every `vp_restart` and `vp_halt` pulse is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, accepted on the same edge |
| bus_rdata | output | DATA_W | Combinational read data |
| vp_restart | output | NUM_VP | Per-processor one-cycle restart request |
| vp_halt | output | NUM_VP | Per-processor one-cycle halt request |
| vp_active | output | NUM_VP | Per-processor executing flag |

## Verification
The embedded assertions check the following on every cycle:
- a restart pulse appears only on a processor's idle-to-active edge, and a halt pulse only on its active-to-idle edge;
- neither pulse lasts more than one cycle;
- the two pulses never coincide on one processor;
- the status vector stays unchanged when no command is decoded.

Only the bench's scenarios can show the rest:
- which processors a given command reaches;
- that out-of-range and unmapped writes are dropped;
- that the remote window matches the local one;
- that the start mask is applied at reset release.

// File: rtl/vp_runctl_pkg.sv
package vp_runctl_pkg;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_START  = 2'd1,
    REG_HALT   = 2'd2,
    REG_STATUS = 2'd3
  } reg_kind_e;

  localparam int NUM_WINDOWS = 2;

  function automatic reg_kind_e kind_of_offset(input int unsigned ofs,
                                               input int unsigned start_ofs,
                                               input int unsigned halt_ofs,
                                               input int unsigned stat_ofs);
    if (ofs == start_ofs)     return REG_START;
    else if (ofs == halt_ofs) return REG_HALT;
    else if (ofs == stat_ofs) return REG_STATUS;
    else                      return REG_NONE;
  endfunction

endpackage

// File: rtl/vp_runctl_decode.sv
module vp_runctl_decode
  import vp_runctl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int LOCAL_BASE  = 'h000,
  parameter int REMOTE_BASE = 'h100,
  parameter int START_OFS   = 'h08,
  parameter int HALT_OFS    = 'h10,
  parameter int STAT_OFS    = 'h18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              start_wr,
  output logic              halt_wr,
  output logic              stat_sel
);

  localparam int WIN_SPAN = 'h20;

  reg_kind_e win_kind [NUM_WINDOWS];

  for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
    localparam int BASE = (w == 0) ? LOCAL_BASE : REMOTE_BASE;
    always_comb begin
      win_kind[w] = REG_NONE;
      if ({20'd0, addr} >= BASE && {20'd0, addr} < BASE + WIN_SPAN)
        win_kind[w] = kind_of_offset(int'({20'd0, addr}) - BASE,
                                     START_OFS, HALT_OFS, STAT_OFS);
    end
  end

  always_comb begin
    start_wr = 1'b0;
    halt_wr  = 1'b0;
    stat_sel = 1'b0;
    for (int w = 0; w < NUM_WINDOWS; w++) begin
      if (win_kind[w] == REG_START)  start_wr = we;
      if (win_kind[w] == REG_HALT)   halt_wr  = we;
      if (win_kind[w] == REG_STATUS) stat_sel = 1'b1;
    end
  end

endmodule

// File: rtl/vp_runctl_lane.sv
module vp_runctl_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic halt_hit,
  output logic active,
  output logic restart_p,
  output logic halt_p
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      restart_p <= 1'b0;
      halt_p    <= 1'b0;
    end else begin
      restart_p <= start_hit & ~active;
      halt_p    <= halt_hit & active & ~start_hit;
      if (start_hit && !active)
        active <= 1'b1;
      else if (halt_hit && active)
        active <= 1'b0;
    end
  end

  AST_RESTART_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_p |-> (active && !$past(active)));  // R4
  AST_HALT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_p |-> (!active && $past(active)));  // R6
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_p |=> !restart_p);  // R11
  AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_p |=> !halt_p);  // R11
  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_p && halt_p));  // R11

endmodule

// File: rtl/vp_runctl_top.sv
module vp_runctl_top #(
  parameter int          NUM_VP      = 1,
  parameter logic [63:0] START_MASK  = 64'h1,
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 64,
  parameter int          LOCAL_BASE  = 'h000,
  parameter int          REMOTE_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_VP-1:0] vp_restart,
  output logic [NUM_VP-1:0] vp_halt,
  output logic [NUM_VP-1:0] vp_active
);

  localparam logic [NUM_VP-1:0] BOOT_SET = START_MASK[NUM_VP-1:0];

  logic              start_wr, halt_wr, stat_sel;
  logic              boot_q;
  logic [NUM_VP-1:0] start_vec, halt_vec;

  initial begin
    AST_START_MASK_FITS: assert ((START_MASK >> NUM_VP) == 64'd0)
      else $error("start mask selects processors beyond NUM_VP");  // R2
  end

  vp_runctl_decode #(
    .ADDR_W      (ADDR_W),
    .LOCAL_BASE  (LOCAL_BASE),
    .REMOTE_BASE (REMOTE_BASE)
  ) decode_i (
    .addr     (bus_addr),
    .we       (bus_we),
    .start_wr (start_wr),
    .halt_wr  (halt_wr),
    .stat_sel (stat_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  always_comb begin
    start_vec = (start_wr ? bus_wdata[NUM_VP-1:0] : '0) | (boot_q ? BOOT_SET : '0);
    halt_vec  = halt_wr ? bus_wdata[NUM_VP-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_lane
    vp_runctl_lane lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_hit (start_vec[i]),
      .halt_hit  (halt_vec[i]),
      .active    (vp_active[i]),
      .restart_p (vp_restart[i]),
      .halt_p    (vp_halt[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_sel) bus_rdata[NUM_VP-1:0] = vp_active;
  end

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_wr && !halt_wr && !boot_q) |=> $stable(vp_active));  // R10
  AST_PULSE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_wr && !halt_wr && !boot_q) |=> (vp_restart == '0 && vp_halt == '0));  // R10

endmodule

// File: tb/vp_runctl_top_tb_top.sv
module vp_runctl_top_tb_top;

  localparam int NV = 4;
  localparam int DW = 64;
  localparam int AW = 12;

  typedef struct {
    logic [NV-1:0] rp;
    logic [NV-1:0] hp;
    logic [NV-1:0] act;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [NV-1:0] vp_restart, vp_halt, vp_active;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  exp_t sb_q[$];
  logic [NV-1:0] model = '0;

  always #4 clk = ~clk;

  vp_runctl_top #(.NUM_VP(NV), .START_MASK(64'h5), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .vp_restart(vp_restart),
    .vp_halt(vp_halt), .vp_active(vp_active));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [NV-1:0] rp, input logic [NV-1:0] hp, input string tag);
    exp_t e;
    e.rp = rp; e.hp = hp; e.act = model; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // kind: 0 idle, 1 start, 2 halt, 3 other write
  task automatic bus_op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
    logic [NV-1:0] m, rp, hp;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = (kind != 0);
    m = d[NV-1:0]; rp = '0; hp = '0;
    if (kind == 1) begin rp = m & ~model; model = model | m; end
    if (kind == 2) begin hp = m & model;  model = model & ~m; end
    @(posedge clk); #1;
    push(rp, hp, tag);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    @(posedge clk); #1;
    push('0, '0, {tag, " idle"});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check({e.tag, " restart"}, DW'(vp_restart), DW'(e.rp));
        check({e.tag, " halt"},    DW'(vp_halt),    DW'(e.hp));
        check({e.tag, " active"},  DW'(vp_active),  DW'(e.act));
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    check("R1 active in reset",  DW'(vp_active), '0);
    check("R1 pulses in reset",  DW'({vp_restart, vp_halt}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    model = 4'b0101;
    @(posedge clk); #1;
    push(4'b0101, '0, "R2 boot start mask");
    bus_read(12'h018, 64'h5, "R9 local status after boot");
    bus_op(1, 12'h008, 64'h3, "R3 R4 start 0011");
    bus_op(0, 12'h000, 64'h0, "R11 idle after restart");
    bus_op(1, 12'h008, 64'h1, "R4 start active vp0");
    bus_op(2, 12'h010, 64'hC, "R5 R6 halt 1100");
    bus_op(0, 12'h000, 64'h0, "R11 idle after halt");
    bus_op(2, 12'h010, 64'h8, "R6 halt idle vp3");
    bus_op(1, 12'h008, 64'hFFFF_FFFF_FFFF_FFF0, "R7 start high bits");
    bus_op(2, 12'h010, 64'h8000_0000_0000_00F0, "R7 halt high bits");
    bus_op(1, 12'h108, 64'h8, "R8 remote start vp3");
    bus_op(2, 12'h110, 64'h1, "R8 remote halt vp0");
    bus_read(12'h118, 64'hA, "R8 R9 remote status");
    bus_read(12'h018, 64'hA, "R9 local status");
    bus_read(12'h008, 64'h0, "R9 start reg reads zero");
    bus_read(12'h7FC, 64'h0, "R9 unmapped read");
    bus_op(3, 12'h7FC, '1, "R10 unmapped write");
    bus_op(3, 12'h020, '1, "R10 past window write");
    bus_op(1, 12'h108, 64'hF, "R3 remote start all");
    bus_op(2, 12'h010, 64'hF, "R5 halt all");
    bus_op(0, 12'h000, 64'h0, "R11 final idle");
    repeat (3) @(negedge clk);
    check("scoreboard drained", DW'(sb_q.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule